// File: doc/BRIEF.md
# Register-List Stack Push Sequencer

This block carries out a compressed multi-register push. A 4-bit list code selects a group of saved registers, and each code includes everything the codes below it select. The block then stores those registers to the stack one at a time, highest register number first. For each store it reads the value through a register-file read port and presents it on a store port that uses a valid/ready handshake.

When the last store has been accepted, the block reports the new stack pointer value and a one-cycle done pulse. The new value is the old stack pointer minus the frame size. The frame size is the register bytes rounded up to 16, plus a byte offset that the caller supplies already scaled. List codes that are not allowed produce an illegal pulse, and nothing else happens for them. A new instruction is accepted only while the block is idle.

Top module: `regpush_seq`

## Requirements
- R1: After reset, `busy`, `done`, `illegal`, `st_valid` and `sp_we` are all low.
- R2: A start with a list code of 0, 1, 2 or 3 raises `illegal` for exactly the one cycle after start. It makes no store and no stack-pointer write, and `busy` stays low.
- R3: With `REDUCED`=1, a list code above 6 is handled like R2. List code 6 is still accepted.
- R4: The selected set grows with the code:
  - code 4 gives {x1};
  - code 5 adds x8, and code 6 adds x9;
  - codes 7 through 14 each add the next register from x18 up to x25;
  - code 15 adds both x26 and x27.
- R5: The stores are issued in strictly descending register-number order. `rf_raddr` gives the register number of the current store.
- R6: The first store address is the start stack pointer minus SLOT bytes, where SLOT = XLEN/8. Each later store address is SLOT bytes lower than the one before.
- R7: Let N be the number of selected registers. One cycle after the last store is accepted, `done` and `sp_we` are high together for exactly one cycle. At that time `sp_wdata` = stack pointer − (round_up_16(N·SLOT) + `stack_imm`).
- R8: While `st_valid` is high and `st_ready` is low, `st_valid`, `st_addr` and `st_data` hold their values into the next cycle.
- R9: A start pulse while `busy` is high is ignored. The push in progress finishes unchanged, and no second push follows it.
- R10: `st_data` carries the value that `rf_rdata` returns for the register on `rf_raddr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a push (sampled while idle) |
| list_code | input | 4 | Register-list code |
| stack_imm | input | IMM_W | Extra frame bytes, already scaled |
| sp_in | input | XLEN | Current stack pointer |
| busy | output | 1 | Push in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle pulse for a disallowed code |
| rf_raddr | output | 5 | Register-file read index |
| rf_rdata | input | XLEN | Register-file read data |
| st_valid | output | 1 | Store request valid |
| st_ready | input | 1 | Store accepted |
| st_addr | output | XLEN | Store byte address |
| st_data | output | XLEN | Store data |
| sp_we | output | 1 | Stack-pointer write strobe |
| sp_wdata | output | XLEN | New stack-pointer value |

## Verification
The push is tried with every class of list code: the single-register code, the codes that add x8 and x9, codes in the x18–x25 run, and code 15, which adds two registers at once. Together these codes tell apart an off-by-one in the register mapping and in the count. The codes are combined with zero and non-zero stack offsets, and with register byte counts that are already multiples of 16 and that are not, so that a missing or wrong rounding step shows up. Runs with `st_ready` stalled every third cycle separate correct holding from early advancing. The same applies to a start pulse injected while busy. The reduced configuration shows that codes above 6 are rejected only there.

// File: rtl/regpush_seq.sv
module regpush_seq #(
  parameter int XLEN    = 32,
  parameter bit REDUCED = 1'b0,
  parameter int IMM_W   = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [3:0]       list_code,
  input  logic [IMM_W-1:0] stack_imm,
  input  logic [XLEN-1:0]  sp_in,
  output logic             busy,
  output logic             done,
  output logic             illegal,
  output logic [4:0]       rf_raddr,
  input  logic [XLEN-1:0]  rf_rdata,
  output logic             st_valid,
  input  logic             st_ready,
  output logic [XLEN-1:0]  st_addr,
  output logic [XLEN-1:0]  st_data,
  output logic             sp_we,
  output logic [XLEN-1:0]  sp_wdata
);
  localparam int SLOT = XLEN / 8;
  localparam logic [XLEN-1:0] SLOT_W = XLEN'(SLOT);
  localparam logic [XLEN-1:0] ALIGN_MASK = ~XLEN'(15);

  typedef enum logic [1:0] {S_IDLE, S_STORE, S_FIN} state_t;

  state_t          state_q;
  logic [3:0]      pos_q;
  logic [XLEN-1:0] addr_q, sp_q, frame_q;
  logic            illegal_q;

  logic            code_bad;
  logic [3:0]      reg_cnt;
  logic [XLEN-1:0] reg_bytes, frame_bytes;

  assign code_bad    = (list_code < 4'd4) || (REDUCED && (list_code > 4'd6));
  assign reg_cnt     = (list_code == 4'd15) ? 4'd13 : list_code - 4'd3;
  assign reg_bytes   = XLEN'(reg_cnt) * SLOT_W;
  assign frame_bytes = ((reg_bytes + XLEN'(15)) & ALIGN_MASK) + XLEN'(stack_imm);

  function automatic logic [4:0] pos_to_reg(input logic [3:0] p);
    case (p)
      4'd0:    return 5'd1;
      4'd1:    return 5'd8;
      4'd2:    return 5'd9;
      default: return 5'(p) + 5'd15;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      pos_q     <= '0;
      addr_q    <= '0;
      sp_q      <= '0;
      frame_q   <= '0;
      illegal_q <= 1'b0;
    end else begin
      illegal_q <= 1'b0;
      case (state_q)
        S_IDLE: if (start) begin
          if (code_bad) begin
            illegal_q <= 1'b1;
          end else begin
            state_q <= S_STORE;
            pos_q   <= reg_cnt - 4'd1;
            addr_q  <= sp_in - SLOT_W;
            sp_q    <= sp_in;
            frame_q <= frame_bytes;
          end
        end
        S_STORE: if (st_ready) begin
          if (pos_q == 4'd0) begin
            state_q <= S_FIN;
          end else begin
            pos_q  <= pos_q - 4'd1;
            addr_q <= addr_q - SLOT_W;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy     = (state_q != S_IDLE);
  assign st_valid = (state_q == S_STORE);
  assign done     = (state_q == S_FIN);
  assign sp_we    = done;
  assign illegal  = illegal_q;
  assign rf_raddr = pos_to_reg(pos_q);
  assign st_addr  = addr_q;
  assign st_data  = rf_rdata;
  assign sp_wdata = sp_q - frame_q;

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && !st_ready |=> st_valid && $stable(st_addr) && $stable(rf_raddr));

  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && $past(st_valid && st_ready) |-> st_addr == $past(st_addr) - SLOT_W);

  // R5
  desc_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && $past(st_valid && st_ready) |-> rf_raddr < $past(rf_raddr));

  // R7
  done_after_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> sp_we && !st_valid && $past(st_valid && st_ready));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  illegal_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !busy && !st_valid && !sp_we);
endmodule

// File: tb/sim_regpush_seq.sv
module sim_regpush_seq;
  localparam int XLEN = 32;
  localparam int SLOT = XLEN / 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic            start = 1'b0, st_ready = 1'b1;
  logic [3:0]      list_code = '0;
  logic [8:0]      stack_imm = '0;
  logic [XLEN-1:0] sp_in = '0;
  logic            busy, done, illegal, st_valid, sp_we;
  logic [4:0]      rf_raddr;
  logic [XLEN-1:0] rf_rdata, st_addr, st_data, sp_wdata;

  assign rf_rdata = {16'hC0DE, 11'h0, rf_raddr};

  regpush_seq #(.XLEN(XLEN), .REDUCED(1'b0), .IMM_W(9)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .list_code(list_code),
    .stack_imm(stack_imm), .sp_in(sp_in), .busy(busy), .done(done),
    .illegal(illegal), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
    .st_data(st_data), .sp_we(sp_we), .sp_wdata(sp_wdata));

  logic            start1 = 1'b0;
  logic [3:0]      code1 = '0;
  logic            busy1, done1, illegal1, st_valid1, sp_we1;
  logic [4:0]      rf_raddr1;
  logic [XLEN-1:0] rf_rdata1, st_addr1, st_data1, sp_wdata1;

  assign rf_rdata1 = {27'h0, rf_raddr1};

  regpush_seq #(.XLEN(XLEN), .REDUCED(1'b1), .IMM_W(9)) u1 (
    .clk(clk), .rst_n(rst_n), .start(start1), .list_code(code1),
    .stack_imm(9'd0), .sp_in(32'h0000_1000), .busy(busy1), .done(done1),
    .illegal(illegal1), .rf_raddr(rf_raddr1), .rf_rdata(rf_rdata1),
    .st_valid(st_valid1), .st_ready(1'b1), .st_addr(st_addr1),
    .st_data(st_data1), .sp_we(sp_we1), .sp_wdata(sp_wdata1));

  int n_tests = 0, n_fail = 0, cycles = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_count(input int code);
    return (code == 15) ? 13 : code - 3;
  endfunction

  function automatic int exp_reg(input int code, input int j);
    int p = exp_count(code) - 1 - j;
    if (p == 0) return 1;
    if (p == 1) return 8;
    if (p == 2) return 9;
    return 18 + (p - 3);
  endfunction

  localparam int NV = 8;
  localparam int V_CODE  [NV] = '{4, 5, 6, 7, 10, 14, 15, 15};
  localparam int V_IMM   [NV] = '{0, 16, 0, 32, 48, 0, 0, 16};
  localparam int V_SP    [NV] = '{32'h1000, 32'h2000, 32'h3F00, 32'h0800,
                                 32'h4000, 32'h5550, 32'h6000, 32'h7010};
  localparam int V_FRAME [NV] = '{16, 32, 16, 48, 80, 48, 64, 80};
  localparam int V_STALL [NV] = '{0, 1, 0, 0, 1, 0, 1, 0};

  task automatic run_push(input int code, input int imm, input int sp,
                          input int frame, input bit stall, input bit inject);
    int j = 0;
    int n = exp_count(code);
    bit pv = 1'b0, pr = 1'b0, seen_done = 1'b0;
    logic [XLEN-1:0] pa = '0, pd = '0;
    @(negedge clk);
    start = 1'b1; list_code = 4'(code); stack_imm = 9'(imm); sp_in = XLEN'(sp);
    @(negedge clk);
    start = 1'b0;
    for (int cyc = 0; cyc < 200; cyc++) begin
      st_ready = stall ? (cyc % 3 != 0) : 1'b1;
      start = (inject && cyc == 1);
      if (start) list_code = 4'd15;
      #1;
      if (pv && !pr) begin
        // R8
        chk(st_valid && st_addr == pa && st_data == pd, "R8", "held store",
            {st_addr, st_data}, {pa, pd});
      end
      if (st_valid && st_ready) begin
        // R4 R5
        chk(32'(rf_raddr) == exp_reg(code, j), "R5", "register order",
            rf_raddr, exp_reg(code, j));
        // R6
        chk(st_addr == XLEN'(sp - (j + 1) * SLOT), "R6", "store address",
            st_addr, sp - (j + 1) * SLOT);
        // R10
        chk(st_data == {16'hC0DE, 11'h0, rf_raddr}, "R10", "store data",
            st_data, {16'hC0DE, 11'h0, rf_raddr});
        j++;
      end
      if (done) begin
        seen_done = 1'b1;
        // R7
        chk(sp_we && sp_wdata == XLEN'(sp - frame), "R7", "new stack pointer",
            sp_wdata, sp - frame);
        // R4
        chk(j == n, "R4", "store count", j, n);
        break;
      end
      pv = st_valid; pr = st_ready; pa = st_addr; pd = st_data;
      @(negedge clk);
    end
    start = 1'b0;
    chk(seen_done, "R7", "done seen", seen_done, 1);
    @(negedge clk); #1;
    // R7 R9
    chk(!done && !sp_we && !busy, inject ? "R9" : "R7", "idle after done",
        {done, sp_we, busy}, 0);
    st_ready = 1'b1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog R7: actual %0d cycles expected fewer than 100000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1
    chk(!busy && !done && !illegal && !st_valid && !sp_we, "R1", "reset outputs",
        {busy, done, illegal, st_valid, sp_we}, 0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++)
      run_push(V_CODE[v], V_IMM[v], V_SP[v], V_FRAME[v], V_STALL[v][0], 1'b0);

    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      start = 1'b1; list_code = 4'(c);
      @(negedge clk);
      start = 1'b0; #1;
      // R2
      chk(illegal && !busy && !st_valid, "R2", "illegal code flagged",
          {illegal, busy, st_valid}, 3'b100);
      @(negedge clk); #1;
      chk(!illegal && !sp_we && !st_valid, "R2", "illegal pulse single",
          {illegal, sp_we, st_valid}, 0);
    end

    // R9
    run_push(7, 0, 32'h9000, 48 - 32, 1'b1, 1'b1);

    @(negedge clk);
    start1 = 1'b1; code1 = 4'd7;
    @(negedge clk);
    start1 = 1'b0; #1;
    // R3
    chk(illegal1 && !busy1, "R3", "reduced rejects code 7", {illegal1, busy1}, 2'b10);
    @(negedge clk);
    start1 = 1'b1; code1 = 4'd6;
    @(negedge clk);
    start1 = 1'b0; #1;
    chk(!illegal1 && busy1, "R3", "reduced accepts code 6", {illegal1, busy1}, 2'b01);
    repeat (3) @(negedge clk);
    #1;
    chk(done1 && sp_wdata1 == 32'h0FF0, "R3", "reduced code 6 frame",
        sp_wdata1, 32'h0FF0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule